// File: doc/BRIEF.md
# Interrupt Controller Command Front End

This block sits at the even command address of one programmable interrupt controller, either the master or the slave of a cascaded pair. Byte writes to that address carry in-band select bits that decide which command word they are. Bits 4 and 3 of the byte pick an initialization-word-1 strobe, an operation-word-2 strobe, or an operation-word-3 update. The two strobes carry the written byte to downstream sequencing and priority logic.

Operation word 3 holds three pieces of state. The first is a special-mask-mode flag. The second is a sticky choice of which register a read returns. The third is a one-shot poll request. Reads of the even address return one of three things: the request vector, the in-service vector, or a poll word built from the pending-interrupt inputs. The request vector, the in-service vector and the highest pending level all come in as inputs.

Top module: `picw_cmd_front`

## Requirements
- R1: The block responds only to the even command address of its own set. With `IS_SLAVE`=0 that is 0x0020 or 0xF020, and with `IS_SLAVE`=1 it is 0x00A0 or 0xF0A0. Reads and writes at any other address, including the odd neighbour, cause no strobe, no state change and no `rd_valid`.
- R2: On an accepted write, byte bits [4:3] route the byte. 00 pulses `op2_stb`, 01 is an operation-word-3 update, and 1x pulses `init_stb`. Each strobe is high for exactly the one cycle after the write cycle, and `cmd_byte` holds the written byte while it is high.
- R3: In an operation-word-3 write, bits [6:5] control special mask mode. 11 sets `special_mask`, 10 clears it, and 00 or 01 leave it unchanged. The new value is visible the cycle after the write.
- R4: In an operation-word-3 write, bits [1:0] choose the read source. 10 selects the request vector, 11 selects the in-service vector, and 00 or 01 keep the earlier choice. The choice persists across any number of reads.
- R5: An accepted read raises `rd_valid` for one cycle, in the cycle after the read. In that cycle `rd_data` is the vector named by the current read source.
- R6: Bit 2 set in an operation-word-3 write arms a poll. The next accepted read returns the poll word instead of the vector: `{irq_any, 4'b0000, irq_level}`. That read disarms the poll, and later reads again return the selected vector.
- R7: An operation-word-3 write with bit 7 set pulses `err_stb` for one cycle. It changes neither the mask flag, nor the read source, nor the poll state, and it pulses neither `init_stb` nor `op2_stb`.
- R8: After reset, `special_mask` is 0, the read source is the request vector, no poll is armed, and all strobes and `rd_valid` are low.
- R9: When a read and a write are accepted in the same cycle, the read is answered from the state held before the write. If that write arms a poll, the poll stays armed even though the same cycle's read consumes an earlier poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Access address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write byte |
| req_vec | input | 8 | Interrupt request vector |
| svc_vec | input | 8 | In-service vector |
| irq_any | input | 1 | Some unmasked request is pending |
| irq_level | input | LVL_W | Highest-priority pending level |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | Read result valid |
| init_stb | output | 1 | Initialization word 1 written |
| op2_stb | output | 1 | Operation word 2 written |
| err_stb | output | 1 | Operation word 3 rejected, bit 7 set |
| cmd_byte | output | 8 | Byte of the last routed write |
| special_mask | output | 1 | Special mask mode active |

## Verification
Reads and writes can fall in the same cycle, and the interesting pairings involve the poll request and the read source. The bench first arms a poll with one write. It then issues a read together with a second poll-arming write in a single cycle. It expects that read to return the poll word and the following read to return the poll word again. In a second case, a read shares its cycle with a write that switches the source to the in-service vector. The read must still return the request vector, and only the next read returns the in-service vector.

// File: rtl/picw_pkg.sv
package picw_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RT_OP2  = 2'd0,
    RT_OP3  = 2'd1,
    RT_INIT = 2'd2
  } route_t;

  typedef enum logic {
    SRC_REQ = 1'b0,
    SRC_SVC = 1'b1
  } rsrc_t;

  // Bits [4:3] pick the command word; bit 4 alone means word 1.
  function automatic route_t route_of(input logic [BYTE_W-1:0] b);
    if (b[4])      return RT_INIT;
    else if (b[3]) return RT_OP3;
    else           return RT_OP2;
  endfunction

  function automatic logic [BYTE_W-1:0] poll_word(input logic any, input logic [2:0] lvl);
    return {any, 4'b0000, lvl};
  endfunction
endpackage

// File: rtl/picw_addr_match.sv
module picw_addr_match #(
  parameter int ADDR_W   = 16,
  parameter bit IS_SLAVE = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] SHORT_A = IS_SLAVE ? ADDR_W'(16'h00A0) : ADDR_W'(16'h0020);
  localparam logic [ADDR_W-1:0] LONG_A  = SHORT_A | ADDR_W'(16'hF000);

  assign hit = (addr == SHORT_A) || (addr == LONG_A);
endmodule

// File: rtl/picw_op3_state.sv
module picw_op3_state
  import picw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op3_wr,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              rd_take,
  output logic              smm,
  output rsrc_t             rsel,
  output logic              poll
);
  logic op3_ok, smm_upd, rsel_upd, poll_set;

  assign op3_ok   = op3_wr && !wbyte[7];
  assign smm_upd  = op3_ok && wbyte[6];
  assign rsel_upd = op3_ok && wbyte[1];
  assign poll_set = op3_ok && wbyte[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smm  <= 1'b0;
      rsel <= SRC_REQ;
      poll <= 1'b0;
    end else begin
      if (smm_upd)  smm  <= wbyte[5];
      if (rsel_upd) rsel <= rsrc_t'(wbyte[0]);
      if (poll_set)     poll <= 1'b1;
      else if (rd_take) poll <= 1'b0;
    end
  end

  // R3: mask flag holds unless an enabled update arrives
  p_smm_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(op3_wr && !wbyte[7] && wbyte[6]) |=> $stable(smm));
  // R4: read source holds without its enable bit
  p_rsel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(op3_wr && !wbyte[7] && wbyte[1]) |=> $stable(rsel));
  // R7: rejected word leaves every piece of state alone
  p_err_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op3_wr && wbyte[7] && !rd_take) |=> ($stable(smm) && $stable(rsel) && $stable(poll)));
  // R6: a consuming read without a fresh arm disarms the poll
  p_poll_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && !poll_set) |=> !poll);
  // R9: a same-cycle arm wins over the consuming read
  p_poll_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && poll_set) |=> poll);
endmodule

// File: rtl/picw_read_mux.sv
module picw_read_mux
  import picw_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_take,
  input  logic              poll,
  input  rsrc_t             rsel,
  input  logic [BYTE_W-1:0] req_vec,
  input  logic [BYTE_W-1:0] svc_vec,
  input  logic              irq_any,
  input  logic [LVL_W-1:0]  irq_level,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [BYTE_W-1:0] sel_vec, next_word;

  assign sel_vec   = (rsel == SRC_SVC) ? svc_vec : req_vec;
  assign next_word = poll ? poll_word(irq_any, 3'(irq_level)) : sel_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_take;
      if (rd_take) rd_data <= next_word;
    end
  end

  // R5: each accepted read yields exactly one valid cycle
  p_rd_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> rd_valid);
  p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_take |=> !rd_valid);
  // R6: poll word keeps its middle bits clear
  p_poll_fmt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && poll) |=> (rd_data[6:3] == 4'b0000));
endmodule

// File: rtl/picw_cmd_front.sv
module picw_cmd_front
  import picw_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int LVL_W    = 3,
  parameter bit IS_SLAVE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  input  logic [7:0]        req_vec,
  input  logic [7:0]        svc_vec,
  input  logic              irq_any,
  input  logic [LVL_W-1:0]  irq_level,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              init_stb,
  output logic              op2_stb,
  output logic              err_stb,
  output logic [7:0]        cmd_byte,
  output logic              special_mask
);
  logic   hit, wr_hit, rd_hit, op3_wr, poll;
  route_t rt;
  rsrc_t  rsel;

  picw_addr_match #(.ADDR_W(ADDR_W), .IS_SLAVE(IS_SLAVE)) u_match (
    .addr(bus_addr), .hit(hit)
  );

  assign wr_hit = bus_wr && hit;
  assign rd_hit = bus_rd && hit;
  assign rt     = route_of(bus_wdata);
  assign op3_wr = wr_hit && (rt == RT_OP3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_stb <= 1'b0;
      op2_stb  <= 1'b0;
      err_stb  <= 1'b0;
      cmd_byte <= '0;
    end else begin
      init_stb <= wr_hit && (rt == RT_INIT);
      op2_stb  <= wr_hit && (rt == RT_OP2);
      err_stb  <= op3_wr && bus_wdata[7];
      if (wr_hit && (rt != RT_OP3)) cmd_byte <= bus_wdata;
    end
  end

  picw_op3_state u_state (
    .clk(clk), .rst_n(rst_n), .op3_wr(op3_wr), .wbyte(bus_wdata),
    .rd_take(rd_hit), .smm(special_mask), .rsel(rsel), .poll(poll)
  );

  picw_read_mux #(.LVL_W(LVL_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_take(rd_hit), .poll(poll), .rsel(rsel),
    .req_vec(req_vec), .svc_vec(svc_vec), .irq_any(irq_any),
    .irq_level(irq_level), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // R1: foreign addresses never produce a strobe
  p_miss_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit) |=> !(init_stb || op2_stb || err_stb || rd_valid));
  // R2: word-1 strobe follows a hit write with bit 4 set, byte carried
  p_init_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit && bus_wdata[4]) |=> (init_stb && cmd_byte == $past(bus_wdata)));
  p_op2_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit && bus_wdata[4:3] == 2'b00) |=> (op2_stb && !init_stb));
  // R7: rejected word raises only the error strobe
  p_err_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit && bus_wdata[4:3] == 2'b01 && bus_wdata[7]) |=> (err_stb && !init_stb && !op2_stb));
endmodule

// File: tb/tb_picw_cmd_front.sv
module tb_picw_cmd_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0, req_vec = '0, svc_vec = '0;
  logic        irq_any = 1'b0;
  logic [2:0]  irq_level = '0;
  logic [7:0]  rd_data, cmd_byte, s_rd_data, s_cmd_byte;
  logic        rd_valid, init_stb, op2_stb, err_stb, special_mask;
  logic        s_rd_valid, s_init, s_op2, s_err, s_smm;

  int   n_vec = 0, n_bad = 0;
  bit   done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  picw_cmd_front dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .req_vec(req_vec), .svc_vec(svc_vec), .irq_any(irq_any),
    .irq_level(irq_level), .rd_data(rd_data), .rd_valid(rd_valid), .init_stb(init_stb),
    .op2_stb(op2_stb), .err_stb(err_stb), .cmd_byte(cmd_byte), .special_mask(special_mask)
  );

  picw_cmd_front #(.IS_SLAVE(1'b1)) dut_s (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .req_vec(req_vec), .svc_vec(svc_vec), .irq_any(irq_any),
    .irq_level(irq_level), .rd_data(s_rd_data), .rd_valid(s_rd_valid), .init_stb(s_init),
    .op2_stb(s_op2), .err_stb(s_err), .cmd_byte(s_cmd_byte), .special_mask(s_smm)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pop one expected item per valid read result
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected rd_valid", rd_data, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rd_data == e, t, rd_data, e);
      end
    end
  end

  // one bus cycle; returns at the negedge where registered results show
  task automatic bus(input logic [15:0] a, input bit w, input bit r, input logic [7:0] d);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus(a, 1'b1, 1'b0, d);
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus(a, 1'b0, 1'b1, 8'h00);
  endtask

  task automatic strobes(input bit i, input bit o, input bit e, input string t);
    chk({init_stb, op2_stb, err_stb} == {i, o, e}, t, {init_stb, op2_stb, err_stb}, {i, o, e});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    chk(special_mask == 1'b0, "R8 smm after reset", special_mask, 0);
    strobes(0, 0, 0, "R8 strobes after reset");
    chk(rd_valid == 1'b0, "R8 rd_valid after reset", rd_valid, 0);
    req_vec = 8'h5A; svc_vec = 8'hC3; irq_any = 1'b1; irq_level = 3'd5;
    rd(16'h0020, 8'h5A, "R8 default source is request vector");

    // R2 routing
    wr(16'h0020, 8'h13); strobes(1, 0, 0, "R2 10 -> init");
    chk(cmd_byte == 8'h13, "R2 cmd_byte init", cmd_byte, 8'h13);
    @(negedge clk); strobes(0, 0, 0, "R2 init single cycle");
    wr(16'h0020, 8'h18); strobes(1, 0, 0, "R2 11 -> init");
    wr(16'h0020, 8'h05); strobes(0, 1, 0, "R2 00 -> op2");
    chk(cmd_byte == 8'h05, "R2 cmd_byte op2", cmd_byte, 8'h05);
    wr(16'h0020, 8'h08); strobes(0, 0, 0, "R2 01 -> op3 no strobe");

    // R3 mask-mode pair
    wr(16'h0020, 8'h68); chk(special_mask == 1, "R3 11 sets", special_mask, 1);
    wr(16'h0020, 8'h28); chk(special_mask == 1, "R3 01 holds", special_mask, 1);
    wr(16'h0020, 8'h48); chk(special_mask == 0, "R3 10 clears", special_mask, 0);
    wr(16'h0020, 8'h08); chk(special_mask == 0, "R3 00 holds", special_mask, 0);

    // R4/R5 read source
    wr(16'h0020, 8'h0B);
    rd(16'h0020, 8'hC3, "R5 in-service selected");
    wr(16'h0020, 8'h09);
    rd(16'h0020, 8'hC3, "R4 01 keeps in-service");
    rd(16'hF020, 8'hC3, "R4 persists over reads, alias");
    wr(16'h0020, 8'h0A);
    rd(16'h0020, 8'h5A, "R4 10 selects request");

    // R6 poll
    wr(16'h0020, 8'h0C);
    rd(16'h0020, 8'h85, "R6 poll word any=1 lvl=5");
    rd(16'h0020, 8'h5A, "R6 poll disarmed after read");
    irq_any = 1'b0; irq_level = 3'd2;
    wr(16'hF020, 8'h0C);
    rd(16'h0020, 8'h02, "R6 poll word any=0 lvl=2");

    // R7 rejected word
    wr(16'h0020, 8'hEB); strobes(0, 0, 1, "R7 err strobe only");
    chk(special_mask == 0, "R7 smm unchanged", special_mask, 0);
    rd(16'h0020, 8'h5A, "R7 source unchanged");
    wr(16'h0020, 8'h8C); strobes(0, 0, 1, "R7 err on poll word");
    rd(16'h0020, 8'h5A, "R7 poll not armed");

    // R1 address decode
    wr(16'h0021, 8'h13); strobes(0, 0, 0, "R1 odd address ignored");
    chk(s_init == 0, "R1 slave ignores master write", s_init, 0);
    wr(16'h00A0, 8'h13); strobes(0, 0, 0, "R1 master ignores slave addr");
    chk(s_init == 1, "R1 slave accepts 0xA0", s_init, 1);
    wr(16'hF0A0, 8'h68);
    chk(special_mask == 0 && s_smm == 1, "R1 alias routes to slave only", {special_mask, s_smm}, 2'b01);
    bus(16'h0021, 1'b0, 1'b1, 8'h00);
    chk(rd_valid == 0, "R1 odd read no valid", rd_valid, 0);
    bus(16'h00A0, 1'b0, 1'b1, 8'h00);
    chk(rd_valid == 0 && s_rd_valid == 1 && s_rd_data == 8'h5A, "R1 slave read",
        {rd_valid, s_rd_valid, s_rd_data}, {2'b01, 8'h5A});

    // R9 same-cycle read and write
    irq_any = 1'b1; irq_level = 3'd7;
    wr(16'h0020, 8'h0C);
    exp_q.push_back(8'h87); tag_q.push_back("R9 read with arming write sees poll");
    bus(16'h0020, 1'b1, 1'b1, 8'h0C);
    rd(16'h0020, 8'h87, "R9 poll stays armed");
    exp_q.push_back(8'h5A); tag_q.push_back("R9 read sees old source");
    bus(16'h0020, 1'b1, 1'b1, 8'h0B);
    rd(16'h0020, 8'hC3, "R9 new source next read");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all reads answered", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule